// File: doc/BRIEF.md
# Register Pending-Load Scoreboard

This block sits beside the decode stage of an in-order pipeline whose data cache keeps running after a miss. Each architectural register has one flag saying its value is still out in the memory system. A load that misses raises the flag of its destination register. When the memory returns the line and the data is written into that register, the flag drops. The pipeline keeps issuing, and it holds an instruction in decode only if that instruction names a register whose flag is up.

Memory latency is unknown and returns may come back in any order. For that reason the block keeps no countdown and no expected-ready time: a flag stays up until its own clear arrives. The destination of the decoding instruction is checked as well as its sources, so a later write cannot be overtaken by an older load that is still in flight. Register 0 is hardwired and is never flagged.

Each register's flag is a two-state machine with the states SLOT_FREE and SLOT_WAIT. The transition FREE_TO_WAIT happens on a set for that register. WAIT_TO_FREE happens on a clear for that register when no set for it arrives in the same cycle. WAIT_HOLD keeps the state in SLOT_WAIT when there is no clear, or when a set and a clear arrive together. FREE_HOLD keeps the state in SLOT_FREE otherwise, and that includes a clear of a register that is not waiting.

Top module: `ldwait_scoreboard`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, every flag is in SLOT_FREE and stall is low.
- R2: A set (set_valid high, set_reg nonzero) on a clock edge flags that register from the next cycle on. Decode in the same cycle as the set still sees the old state.
- R3: A clear (clr_valid high) on a clock edge, with no set for the same register at that edge, frees that register from the next cycle on.
- R4: stall is high when dec_valid is high and a used source operand names a flagged register. dec_use bit 0 marks dec_rs1 as used and bit 1 marks dec_rs2 as used.
- R5: stall is high when dec_valid is high, dec_use bit 2 is set, and dec_rd names a flagged register.
- R6: stall is low when dec_valid is low, or when no used operand names a flagged register, including when dec_use is 0.
- R7: A set and a clear of the same register on the same edge leave that register flagged.
- R8: Register 0 is never flagged. A set of register 0 has no effect, and operands that name register 0 never cause a stall.
- R9: Flags of different registers are independent. A clear frees only its own register, and a clear of a register that is not flagged changes nothing.
- R10: A flag stays set for any number of cycles until its clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | A load missed this cycle |
| set_reg | input | IDX_W | Destination register of the missing load |
| clr_valid | input | 1 | Miss data is written back this cycle |
| clr_reg | input | IDX_W | Register receiving the returned data |
| dec_valid | input | 1 | An instruction is in decode |
| dec_rs1 | input | IDX_W | First source register of the decoding instruction |
| dec_rs2 | input | IDX_W | Second source register of the decoding instruction |
| dec_rd | input | IDX_W | Destination register of the decoding instruction |
| dec_use | input | 3 | Operand-used flags: bit 0 rs1, bit 1 rs2, bit 2 rd |
| stall | output | 1 | Hold the decoding instruction |

## Verification
The hardest case to reach is one where the state after an edge depends on two requests arriving together. This happens when a set and a clear name the same register, or when a clear names a register other than the one still waiting. The stimulus table puts both requests into one vector. The following vector then probes the register through a decode operand, so the outcome shows at stall. A long directed wait confirms that the flag survives a thousand cycles with no return.

// File: rtl/scb_pkg.sv
package scb_pkg;
    // Per-register pending state
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_WAIT = 1'b1
    } slot_state_t;

    // Operand positions inside the decode use mask
    localparam int OP_RS1 = 0;
    localparam int OP_RS2 = 1;
    localparam int OP_RD  = 2;
    localparam int OP_CNT = 3;
endpackage

// File: rtl/scb_slot.sv
module scb_slot
    import scb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    output logic busy
);
    slot_state_t state_q;
    slot_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: FREE_TO_WAIT, WAIT_TO_FREE, WAIT_HOLD, FREE_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (set_hit) begin
                    state_d = SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                // a set in the same cycle belongs to a newer miss and wins
                if (clr_hit && !set_hit) begin
                    state_d = SLOT_FREE;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // Output process
    always_comb begin
        busy = 1'b0;
        unique case (state_q)
            SLOT_FREE: busy = 1'b0;
            SLOT_WAIT: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard
    import scb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]   busy_vec,
    input  logic              dec_valid,
    input  logic [IDX_W-1:0]  dec_rs1,
    input  logic [IDX_W-1:0]  dec_rs2,
    input  logic [IDX_W-1:0]  dec_rd,
    input  logic [OP_CNT-1:0] dec_use,
    output logic              stall
);
    logic [IDX_W-1:0]  op_idx [OP_CNT];
    logic [OP_CNT-1:0] op_hit;

    assign op_idx[OP_RS1] = dec_rs1;
    assign op_idx[OP_RS2] = dec_rs2;
    assign op_idx[OP_RD]  = dec_rd;

    for (genvar k = 0; k < OP_CNT; k++) begin : g_op
        assign op_hit[k] = dec_use[k] && busy_vec[op_idx[k]];
    end

    assign stall = dec_valid && (|op_hit);
endmodule

// File: rtl/ldwait_scoreboard.sv
module ldwait_scoreboard
    import scb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [IDX_W-1:0]  set_reg,
    input  logic              clr_valid,
    input  logic [IDX_W-1:0]  clr_reg,
    input  logic              dec_valid,
    input  logic [IDX_W-1:0]  dec_rs1,
    input  logic [IDX_W-1:0]  dec_rs2,
    input  logic [IDX_W-1:0]  dec_rd,
    input  logic [OP_CNT-1:0] dec_use,
    output logic              stall
);
    logic [NREG-1:0] busy_vec;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == 0) begin : g_zero
            // hardwired register never waits on memory
            assign busy_vec[r] = 1'b0;
        end else begin : g_slot
            logic set_hit;
            logic clr_hit;
            assign set_hit = set_valid && (set_reg == IDX_W'(r));
            assign clr_hit = clr_valid && (clr_reg == IDX_W'(r));
            scb_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_hit (set_hit),
                .clr_hit (clr_hit),
                .busy    (busy_vec[r])
            );
        end
    end

    scb_hazard #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_hazard (
        .busy_vec  (busy_vec),
        .dec_valid (dec_valid),
        .dec_rs1   (dec_rs1),
        .dec_rs2   (dec_rs2),
        .dec_rd    (dec_rd),
        .dec_use   (dec_use),
        .stall     (stall)
    );
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_valid,
    input logic [IDX_W-1:0] set_reg,
    input logic             clr_valid,
    input logic [IDX_W-1:0] clr_reg,
    input logic             dec_valid,
    input logic [IDX_W-1:0] dec_rs1,
    input logic [IDX_W-1:0] dec_rs2,
    input logic [IDX_W-1:0] dec_rd,
    input logic [2:0]       dec_use,
    input logic             stall
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !stall);

    assert_set_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_valid) && $past(set_reg) != '0 &&
         dec_valid && dec_use[0] && dec_rs1 == $past(set_reg)) |-> stall);

    assert_clear_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_valid) &&
         !($past(set_valid) && $past(set_reg) == $past(clr_reg)) &&
         dec_use == 3'b001 && dec_rs1 == $past(clr_reg)) |-> !stall);

    assert_idle_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid || dec_use == 3'b000) |-> !stall);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_valid) && $past(clr_valid) &&
         $past(set_reg) == $past(clr_reg) && $past(set_reg) != '0 &&
         dec_valid && dec_use[0] && dec_rs1 == $past(set_reg)) |-> stall);

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rs1 == '0 && dec_rs2 == '0 && dec_rd == '0) |-> !stall);
endmodule

bind ldwait_scoreboard scb_checker #(
    .NREG  (NREG),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (set_valid),
    .set_reg   (set_reg),
    .clr_valid (clr_valid),
    .clr_reg   (clr_reg),
    .dec_valid (dec_valid),
    .dec_rs1   (dec_rs1),
    .dec_rs2   (dec_rs2),
    .dec_rd    (dec_rd),
    .dec_use   (dec_use),
    .stall     (stall)
);

// File: tb/sim_ldwait_scoreboard.sv
module sim_ldwait_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_valid = 1'b0;
    logic [4:0] set_reg = '0;
    logic       clr_valid = 1'b0;
    logic [4:0] clr_reg = '0;
    logic       dec_valid = 1'b0;
    logic [4:0] dec_rs1 = '0;
    logic [4:0] dec_rs2 = '0;
    logic [4:0] dec_rd = '0;
    logic [2:0] dec_use = '0;
    logic       stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ldwait_scoreboard u0 (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_reg(set_reg),
        .clr_valid(clr_valid), .clr_reg(clr_reg),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_rd(dec_rd), .dec_use(dec_use),
        .stall(stall)
    );

    typedef struct packed {
        logic       sv;
        logic [4:0] sr;
        logic       cv;
        logic [4:0] cr;
        logic       dv;
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] d;
        logic [2:0] u;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5, 5'd0, 5'd0, 3'b001, 1'b0, 4'd1}, // R1 fresh state
        '{1'b1, 5'd5,  1'b0, 5'd0,  1'b1, 5'd5, 5'd0, 5'd0, 3'b001, 1'b0, 4'd2}, // R2 same cycle unseen
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5, 5'd0, 5'd0, 3'b001, 1'b1, 4'd4}, // R4 rs1 busy
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd1, 5'd5, 5'd0, 3'b010, 1'b1, 4'd4}, // R4 rs2 busy
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5, 5'd0, 5'd5, 3'b100, 1'b1, 4'd5}, // R5 rd busy
        '{1'b0, 5'd0,  1'b1, 5'd5,  1'b1, 5'd5, 5'd5, 5'd5, 3'b000, 1'b0, 4'd6}, // R6 nothing used
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5, 5'd0, 5'd0, 3'b001, 1'b0, 4'd3}, // R3 freed
        '{1'b1, 5'd7,  1'b1, 5'd7,  1'b1, 5'd7, 5'd0, 5'd0, 3'b001, 1'b0, 4'd7}, // R7 set+clear
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd7, 5'd0, 5'd0, 3'b001, 1'b1, 4'd7}, // R7 set won
        '{1'b1, 5'd0,  1'b1, 5'd7,  1'b1, 5'd6, 5'd0, 5'd0, 3'b001, 1'b0, 4'd8}, // R8 set of reg 0
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd0, 5'd0, 5'd0, 3'b111, 1'b0, 4'd8}, // R8 reg 0 clean
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd7, 5'd0, 5'd0, 3'b001, 1'b0, 4'd3}, // R3 reg 7 freed
        '{1'b1, 5'd3,  1'b0, 5'd0,  1'b0, 5'd0, 5'd0, 5'd0, 3'b000, 1'b0, 4'd9}, // R9 set 3
        '{1'b1, 5'd9,  1'b0, 5'd0,  1'b1, 5'd3, 5'd0, 5'd0, 3'b001, 1'b1, 4'd9}, // R9 set 9
        '{1'b0, 5'd0,  1'b1, 5'd3,  1'b1, 5'd2, 5'd9, 5'd0, 3'b010, 1'b1, 4'd9}, // R9 clear 3
        '{1'b0, 5'd0,  1'b1, 5'd12, 1'b1, 5'd3, 5'd0, 5'd0, 3'b001, 1'b0, 4'd9}, // R9 only 3 freed
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd4, 5'd4, 5'd9, 3'b100, 1'b1, 4'd9}, // R9 idle clear harmless
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd9, 5'd9, 5'd9, 3'b111, 1'b0, 4'd6}, // R6 no decode
        '{1'b0, 5'd0,  1'b1, 5'd9,  1'b1, 5'd9, 5'd0, 5'd0, 3'b001, 1'b1, 4'd9}, // R9 clear not yet seen
        '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd9, 5'd0, 5'd0, 3'b001, 1'b0, 4'd3}  // R3 reg 9 freed
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: stall=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic sv, input logic [4:0] sr, input logic cv,
                         input logic [4:0] cr, input logic dv, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d, input logic [2:0] u);
        set_valid = sv; set_reg = sr; clr_valid = cv; clr_reg = cr;
        dec_valid = dv; dec_rs1 = a; dec_rs2 = b; dec_rd = d; dec_use = u;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: in reset nothing stalls
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 5'd5, 5'd5, 3'b111);
        #4 check("R1", stall, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i].sv, VT[i].sr, VT[i].cv, VT[i].cr, VT[i].dv,
                  VT[i].a, VT[i].b, VT[i].d, VT[i].u);
            #4 check($sformatf("R%0d vec%0d", VT[i].req, i), stall, VT[i].exp);
        end

        // R10: a flag survives a long wait with no return
        @(negedge clk);
        drive(1'b1, 5'd20, 1'b0, 5'd0, 1'b1, 5'd20, 5'd0, 5'd0, 3'b001);
        for (int c = 1; c <= 1000; c++) begin
            @(negedge clk);
            drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd20, 5'd0, 5'd0, 3'b001);
            if (c % 250 == 0) begin
                #4 check("R10", stall, 1'b1);
            end
        end
        @(negedge clk);
        drive(1'b0, 5'd0, 1'b1, 5'd20, 1'b1, 5'd20, 5'd0, 5'd0, 3'b001);
        #4 check("R10", stall, 1'b1);
        @(negedge clk);
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd20, 5'd0, 5'd0, 3'b001);
        #4 check("R10", stall, 1'b0);

        // R1: reset clears pending flags
        @(negedge clk);
        drive(1'b1, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 3'b000);
        @(negedge clk);
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd4, 5'd0, 5'd0, 3'b001);
        #4 check("R1", stall, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #4 check("R1", stall, 1'b0);

        // R8: register 0 stays clean on every operand after a set
        @(negedge clk);
        drive(1'b1, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 3'b111);
        @(negedge clk);
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 3'b111);
        #4 check("R8", stall, 1'b0);

        @(negedge clk);
        finish_run();
    end
endmodule